// File: doc/BRIEF.md
# Two-Upstream-Channel STOP-Gated Connect Controller

This controller decides which of two upstream two-wire serial buses (channel 0 and channel 1) is joined to a single downstream bus. It watches the clock and data lines of both upstream buses and finds START and STOP conditions on each. From these events it tracks whether each bus is busy. It drives one connect enable per upstream channel, and those enables control the external switch elements.

How the block behaves after reset depends on a mode input sampled during reset. In immediate mode, channel 0 is joined at once. In wait mode, nothing is joined until a STOP appears on channel 0. Either way, that STOP closes whatever transfer was under way, and the transfer does not have to be addressed to this block. The channel 1 master can ask to take over at any time, including before the default connection has been made. It does so with a one-cycle request pulse. The request is held until a STOP is seen on channel 1, and at that moment the connection moves to channel 1.

The block has no data stream. It has no valid/ready interface and no back-pressure. All pins are plain control and status signals.

Top module: `upstream_connect_ctrl`

## Requirements
- R1: In immediate mode (`wait_stop_mode`=0), `conn_ch0`=1 and `conn_ch1`=0 while `rst_n` is low and from the first cycle after release.
- R2: In wait mode (`wait_stop_mode`=1), both connect enables are 0 during reset and afterwards. `conn_ch0` rises only at a STOP on channel 0. It rises three clock edges after the SDA rise: two synchronizer flops, then the state register.
- R3: In wait mode, a START on channel 0 followed by data bits does not connect. The STOP that ends that transfer does connect channel 0.
- R4: A STOP on channel 1 with no switch request outstanding changes neither connect enable.
- R5: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. SDA edges while SCL is low are neither, and they change no output.
- R6: `bus_busy[c]` (bit 0 = channel 0, bit 1 = channel 1) is set by a START on that channel and cleared by a STOP on it.
- R7: A one-cycle `ch1_switch_req` pulse is latched. At the next STOP on channel 1, `conn_ch1` rises and `conn_ch0` falls on the same edge.
- R8: A request made before the default connection is served by a channel 1 STOP directly from the unconnected state. If a channel 0 STOP comes first, channel 0 connects and the request stays pending.
- R9: A STOP on channel 0 never serves a pending request. The request stays latched through any number of channel 0 transfers.
- R10: `conn_ch0` and `conn_ch1` are never both 1 in any cycle.
- R11: Once `conn_ch1` is 1, further requests and STOPs on either channel do not change the connect enables.
- R12: Reset clears a pending request and both busy flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wait_stop_mode | input | 1 | Sampled in reset: 0 immediate connect of channel 0, 1 wait for channel 0 STOP |
| up_scl | input | 2 | Upstream SCL lines, bit c = channel c |
| up_sda | input | 2 | Upstream SDA lines, bit c = channel c |
| ch1_switch_req | input | 1 | One-cycle request from the channel 1 master to take the downstream bus |
| conn_ch0 | output | 1 | Connect enable for channel 0 |
| conn_ch1 | output | 1 | Connect enable for channel 1 |
| bus_busy | output | 2 | Busy flag per upstream channel |

## Verification
Suppose the state register or the pending-request latch holds a wrong value. The connect enables then show it within three edges of the next STOP on the channel concerned. Channel 0 would connect, or fail to connect, at the wrong STOP, or the request would be served by the wrong channel's STOP. A fault in the condition detectors shows on `bus_busy` three edges after the offending SDA edge. The bench therefore follows every bus event with a short settle window before it samples. It sweeps the mode, the point at which the request arrives, and whether channel 0 was busy, and it computes the expected enables for each case.

// File: rtl/ucc_pkg.sv
package ucc_pkg;
  typedef enum logic [1:0] {
    LINK_NONE    = 2'd0,
    LINK_CH0     = 2'd1,
    LINK_CH0_REQ = 2'd2,
    LINK_CH1     = 2'd3
  } link_state_t;

  typedef struct packed {
    logic start;
    logic stop;
  } bus_event_t;
endpackage

// File: rtl/ucc_sync.sv
module ucc_sync #(
  parameter int  STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q,
  output logic q_prev
);
  logic [STAGES-1:0] chain;
  logic              prev_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain  <= {STAGES{RESET_VAL}};
      prev_r <= RESET_VAL;
    end else begin
      chain  <= {chain[STAGES-2:0], d};
      prev_r <= chain[STAGES-1];
    end
  end

  assign q      = chain[STAGES-1];
  assign q_prev = prev_r;
endmodule

// File: rtl/ucc_bus_monitor.sv
module ucc_bus_monitor
  import ucc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl,
  input  logic       sda,
  output bus_event_t ev,
  output logic       busy
);
  logic scl_q, scl_p, sda_q, sda_p;
  logic busy_r;

  ucc_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_scl (
    .clk(clk), .rst_n(rst_n), .d(scl), .q(scl_q), .q_prev(scl_p));
  ucc_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sda (
    .clk(clk), .rst_n(rst_n), .d(sda), .q(sda_q), .q_prev(sda_p));

  // SCL high across both samples; SDA edge decides the condition
  always_comb begin
    ev.start = scl_q && scl_p && sda_p && !sda_q;
    ev.stop  = scl_q && scl_p && !sda_p && sda_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        busy_r <= 1'b0;
    else if (ev.start) busy_r <= 1'b1;
    else if (ev.stop)  busy_r <= 1'b0;
  end

  assign busy = busy_r;

  a_r6_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    ev.start |=> busy);
  a_r6_stop_clears_busy: assert property (@(posedge clk) disable iff (!rst_n)
    ev.stop |=> !busy);
  a_r5_busy_moves_on_event: assert property (@(posedge clk) disable iff (!rst_n)
    !ev.start && !ev.stop |=> $stable(busy));
endmodule

// File: rtl/upstream_connect_ctrl.sv
module upstream_connect_ctrl
  import ucc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wait_stop_mode,
  input  logic [1:0] up_scl,
  input  logic [1:0] up_sda,
  input  logic       ch1_switch_req,
  output logic       conn_ch0,
  output logic       conn_ch1,
  output logic [1:0] bus_busy
);
  localparam int NUM_CH = 2;

  bus_event_t  ev [NUM_CH];
  link_state_t state, state_nxt;
  logic        pend;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_mon
    ucc_bus_monitor #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
      .clk(clk), .rst_n(rst_n),
      .scl(up_scl[c]), .sda(up_sda[c]),
      .ev(ev[c]), .busy(bus_busy[c]));
  end

  always_comb begin
    state_nxt = state;
    unique case (state)
      LINK_NONE: begin
        if (pend && ev[1].stop)  state_nxt = LINK_CH1;
        else if (ev[0].stop)     state_nxt = LINK_CH0;
      end
      LINK_CH0: begin
        if (pend && ev[1].stop)  state_nxt = LINK_CH1;
        else if (pend)           state_nxt = LINK_CH0_REQ;
      end
      LINK_CH0_REQ: begin
        if (ev[1].stop)          state_nxt = LINK_CH1;
      end
      LINK_CH1:                  state_nxt = LINK_CH1;
      default:                   state_nxt = LINK_NONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= wait_stop_mode ? LINK_NONE : LINK_CH0;
      pend  <= 1'b0;
    end else begin
      state <= state_nxt;
      if (state_nxt == LINK_CH1)                      pend <= 1'b0;
      else if (ch1_switch_req && state != LINK_CH1)   pend <= 1'b1;
    end
  end

  assign conn_ch0 = (state == LINK_CH0) || (state == LINK_CH0_REQ);
  assign conn_ch1 = (state == LINK_CH1);

  a_r10_exclusive: assert property (@(posedge clk)
    $onehot0({conn_ch0, conn_ch1}));
  a_r7_ch1_at_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conn_ch1) |-> $past(ev[1].stop));
  a_r2_ch0_at_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conn_ch0) |-> $past(ev[0].stop));
  a_r11_ch1_holds: assert property (@(posedge clk) disable iff (!rst_n)
    conn_ch1 |=> conn_ch1 && !conn_ch0);
  a_r9_ch0_leaves_only_to_ch1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(conn_ch0) |-> conn_ch1);
  a_r4_no_req_no_ch1: assert property (@(posedge clk) disable iff (!rst_n)
    !pend && !conn_ch1 |=> !conn_ch1);
endmodule

// File: tb/tb_upstream_connect_ctrl.sv
module tb_upstream_connect_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wait_stop_mode = 1'b0;
  logic [1:0] up_scl = 2'b11;
  logic [1:0] up_sda = 2'b11;
  logic       ch1_switch_req = 1'b0;
  logic       conn_ch0, conn_ch1;
  logic [1:0] bus_busy;
  int         total = 0;
  int         fails = 0;
  int         overlap = 0;

  always #4 clk = ~clk;

  upstream_connect_ctrl dut (
    .clk(clk), .rst_n(rst_n), .wait_stop_mode(wait_stop_mode),
    .up_scl(up_scl), .up_sda(up_sda), .ch1_switch_req(ch1_switch_req),
    .conn_ch0(conn_ch0), .conn_ch1(conn_ch1), .bus_busy(bus_busy));

  always @(negedge clk) if (conn_ch0 && conn_ch1) overlap++;

  task automatic chk(string req, logic act, logic exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic set_line(int ch, logic scl, logic sda);
    @(negedge clk);
    up_scl[ch] = scl;
    up_sda[ch] = sda;
    repeat (4) @(posedge clk);
  endtask

  task automatic bus_start(int ch);
    set_line(ch, 1, 1); set_line(ch, 1, 0); set_line(ch, 0, 0);
  endtask

  task automatic bus_stop(int ch);
    set_line(ch, 0, 0); set_line(ch, 1, 0); set_line(ch, 1, 1);
  endtask

  task automatic data_bits(int ch);
    set_line(ch, 0, 1); set_line(ch, 1, 1); set_line(ch, 0, 1);
    set_line(ch, 0, 0); set_line(ch, 1, 0); set_line(ch, 0, 0);
  endtask

  task automatic settle();
    repeat (6) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_req();
    @(negedge clk) ch1_switch_req = 1'b1;
    @(negedge clk) ch1_switch_req = 1'b0;
  endtask

  task automatic do_reset(logic m);
    @(negedge clk);
    rst_n = 1'b0; wait_stop_mode = m; up_scl = 2'b11; up_sda = 2'b11;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(m ? "R2 reset conn0" : "R1 reset conn0", conn_ch0, !m);
    chk("R1 R2 reset conn1", conn_ch1, 1'b0);
    chk("R12 reset busy", |bus_busy, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(m ? "R2 after release conn0" : "R1 after release conn0", conn_ch0, !m);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    // Sweep: mode x request position x channel 0 busy before its STOP
    for (int m = 0; m < 2; m++) begin
      for (int p = 0; p < 3; p++) begin
        for (int b = 0; b < 2; b++) begin
          do_reset(logic'(m));
          if (b == 1) begin
            bus_start(0);
            data_bits(0);
            settle();
            chk("R6 busy0 after START", bus_busy[0], 1'b1);
            chk("R3 no connect mid-transfer", conn_ch0, m == 0);
          end
          if (p == 1) pulse_req();
          bus_stop(0);
          settle();
          chk("R6 busy0 after STOP", bus_busy[0], 1'b0);
          chk("R2 R3 R8 conn0 after ch0 STOP", conn_ch0, 1'b1);
          chk("R9 ch0 STOP does not serve", conn_ch1, 1'b0);
          if (p == 2) begin
            pulse_req();
            settle();
            chk("R9 pending, still ch0", conn_ch0, 1'b1);
            bus_start(0); bus_stop(0); settle();
            chk("R9 second ch0 STOP no switch", conn_ch1, 1'b0);
          end
          bus_start(1);
          settle();
          chk("R6 busy1 after START", bus_busy[1], 1'b1);
          bus_stop(1);
          settle();
          chk(p != 0 ? "R7 conn1 at ch1 STOP" : "R4 ch1 STOP no request", conn_ch1, p != 0);
          chk(p != 0 ? "R7 conn0 dropped" : "R4 conn0 kept", conn_ch0, p == 0);
          if (p != 0) begin
            pulse_req();
            bus_start(0); bus_stop(0);
            bus_start(1); bus_stop(1);
            settle();
            chk("R11 conn1 held", conn_ch1, 1'b1);
            chk("R11 conn0 stays off", conn_ch0, 1'b0);
          end
        end
      end
    end

    // R8: request while unconnected, served straight by ch1 STOP
    do_reset(1'b1);
    pulse_req();
    bus_stop(1);
    settle();
    chk("R8 direct to ch1", conn_ch1, 1'b1);
    chk("R8 ch0 never on", conn_ch0, 1'b0);

    // R5: SDA edges while SCL low are not conditions
    do_reset(1'b1);
    set_line(0, 0, 1); set_line(0, 0, 0); set_line(0, 0, 1); set_line(0, 1, 1);
    settle();
    chk("R5 no STOP with SCL low", conn_ch0, 1'b0);
    chk("R5 no START with SCL low", bus_busy[0], 1'b0);

    // R12: reset drops a pending request and busy flags
    do_reset(1'b1);
    pulse_req();
    bus_start(0);
    settle();
    chk("R6 busy0 set pre-reset", bus_busy[0], 1'b1);
    do_reset(1'b1);
    bus_stop(1);
    settle();
    chk("R12 request cleared by reset", conn_ch1, 1'b0);

    chk("R10 never both connected", overlap == 0, 1'b1);
    summary();
  end
endmodule